// File: doc/BRIEF.md
# Codec Time Slot Assigner

This block places framing strobes for a group of four voice codecs on a shared serial highway. Each codec has a transmit strobe and a receive strobe. Each strobe can be placed on its own in any one of up to 64 eight-bit time slots. The slots are counted from external frame-start pulses that are synchronous to the bit clock. An assigned strobe goes high for one full slot, which is eight bit clocks, once per frame. An active-low flag marks every bit-clock period in which any transmit strobe is high.

Assignments are written through a small serial port that has its own clock, a data line and an active-low select. Each word carries three fields: a direction bit, an enable bit and a slot number. The channel the word programs comes from select pins. A mode pin decides how one shared pin is used. In one mode it is the receive frame-start input. In the other it is the top bit of the channel select, and the receive count then follows the transmit frame-start.

All inputs, including the bit clock and the control clock, are sampled by one fast system clock and arrive synchronous to it. Edges of the slow clocks are detected internally, so the whole block runs on a single clock.

Top module: `tsa_codec_slots`

## Requirements
- R1: While reset is high and on the cycle after it, every transmit and receive strobe is low and the transmit-slot flag `tslot_n` is high. All assignments are cleared to disabled.
- R2: A frame-start input seen high at a bit-clock rising edge makes that bit clock bit 0 of slot 0. Each later rising edge advances one bit. Eight bits make a slot, and the 6-bit slot number wraps from 63 to 0 if no new frame-start arrives.
- R3: An enabled strobe goes high at the bit-clock falling edge inside bit 0 of its assigned slot. It stays high for exactly eight bit clocks. Strobes change only one system-clock cycle after a bit-clock falling edge is seen.
- R4: Transmit strobes follow the transmit slot count and receive strobes follow the receive slot count. Each of the eight strobe assignments is independent of the others.
- R5: `tslot_n` is low exactly while at least one transmit strobe is high, and high otherwise.
- R6: A control word is 8 bits, shifted MSB first on rising edges of `ctl_clk` while `ctl_sel_n` is low. Bit 7 = 1 selects transmit and 0 selects receive. Bit 6 = 1 enables and 0 disables. Bits 5..0 hold the slot number. The word takes effect when `ctl_sel_n` rises.
- R7: A select window that contains any number of control-clock edges other than eight changes no assignment.
- R8: The channel-select pins are sampled at every control-clock rising edge, and the last sample picks the channel the word programs. The number is {msb, `ch_sel[1]`, `ch_sel[0]`}.
- R9: With `mode` high, `rsync_ch2` is the receive frame-start and the channel-select msb is 0. With `mode` low, `rsync_ch2` is the channel-select msb, the receive count restarts on `tx_sync`, and channel numbers 4 to 7 are ignored.
- R10: Before the first frame-start of a direction has been seen after reset, no strobe of that direction goes high, even if it has an enabled assignment.
- R11: A word with the enable bit at 0 stops the addressed strobe from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst | input | 1 | Synchronous reset, active high |
| bclk | input | 1 | Bit clock of the serial highway |
| tx_sync | input | 1 | Transmit frame-start pulse, one bit clock wide |
| rsync_ch2 | input | 1 | Receive frame-start (mode high) or channel-select msb (mode low) |
| mode | input | 1 | Selects how `rsync_ch2` is used |
| ctl_clk | input | 1 | Control port shift clock |
| ctl_sel_n | input | 1 | Control port select, active low |
| ctl_data | input | 1 | Control port serial data, MSB first |
| ch_sel | input | 2 | Lower two channel-select bits |
| fsx | output | 4 | Transmit strobes, one per channel |
| fsr | output | 4 | Receive strobes, one per channel |
| tslot_n | output | 1 | Low while any transmit strobe is high |

## Verification
The bench builds the block with its default parameters: four channels, 6-bit slot numbers and 8-bit control words. It drives frames 512 bit clocks long, so a strobe on slot 63 ends right against the next frame-start. With three channel-select bits the bench can reach the ignored channel numbers 4 to 7 in the second mode. It also runs the same receive assignment under both frame-start sources and checks that transmit and receive strobes overlap only when the receive count follows the transmit frame-start.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    // channels served and field widths
    localparam int unsigned NUM_CH        = 4;
    localparam int unsigned SLOT_W        = 6;
    localparam int unsigned BIT_W         = 3;
    localparam int unsigned BITS_PER_SLOT = 1 << BIT_W;
    localparam int unsigned WORD_W        = SLOT_W + 2;
    localparam int unsigned CSEL_W        = 3;
    localparam int unsigned POS_W         = SLOT_W + BIT_W;

    // serial control word as shifted in, MSB first
    typedef struct packed {
        logic              is_tx;
        logic              enable;
        logic [SLOT_W-1:0] slot;
    } ctl_word_t;

    // one stored strobe assignment
    typedef struct packed {
        logic              enable;
        logic [SLOT_W-1:0] slot;
    } assign_t;

    // position inside the frame
    typedef struct packed {
        logic              locked;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } pos_t;

    function automatic assign_t to_assign(ctl_word_t w);
        assign_t a;
        a.enable = w.enable;
        a.slot   = w.slot;
        return a;
    endfunction

    function automatic logic slot_hit(assign_t a, pos_t p);
        return a.enable && p.locked && (a.slot == p.slot);
    endfunction

endpackage

// File: rtl/tsa_slot_counter.sv
module tsa_slot_counter
    import tsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bclk_rise,
    input  logic frame_start,
    output pos_t pos
);

    logic [POS_W-1:0] flat_next;

    assign flat_next = {pos.slot, pos.bitn} + POS_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (bclk_rise) begin
            if (frame_start) begin
                pos.locked <= 1'b1;
                pos.slot   <= '0;
                pos.bitn   <= '0;
            end else if (pos.locked) begin
                pos.slot   <= flat_next[POS_W-1:BIT_W];
                pos.bitn   <= flat_next[BIT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tsa_ctl_port.sv
module tsa_ctl_port
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_clk,
    input  logic              ctl_sel_n,
    input  logic              ctl_data,
    input  logic [CSEL_W-1:0] csel,
    output logic [NUM_CH-1:0] tx_we,
    output logic [NUM_CH-1:0] rx_we,
    output assign_t           wr_asg
);

    localparam int unsigned       CNT_W    = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0]  FULL     = CNT_W'(WORD_W);
    localparam logic [CSEL_W:0]   CH_LIMIT = (CSEL_W + 1)'(NUM_CH);

    logic              cclk_d;
    logic              sel_d;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  nbits;
    logic [CSEL_W-1:0] chan;
    logic              cclk_rise;
    logic              sel_rise;
    logic              commit;
    ctl_word_t         word;

    assign cclk_rise = ctl_clk && !cclk_d;
    assign sel_rise  = ctl_sel_n && !sel_d;
    assign word      = ctl_word_t'(shreg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cclk_d <= 1'b0;
            sel_d  <= 1'b1;
            shreg  <= '0;
            nbits  <= '0;
            chan   <= '0;
        end else begin
            cclk_d <= ctl_clk;
            sel_d  <= ctl_sel_n;
            if (ctl_sel_n) begin
                nbits <= '0;
            end else if (cclk_rise) begin
                shreg <= {shreg[WORD_W-2:0], ctl_data};
                chan  <= csel;
                if (nbits != '1) begin
                    nbits <= nbits + CNT_W'(1);
                end
            end
        end
    end

    assign commit = sel_rise && (nbits == FULL) && ({1'b0, chan} < CH_LIMIT);
    assign wr_asg = to_assign(word);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        assign tx_we[c] = commit &&  word.is_tx && (chan == CSEL_W'(c));
        assign rx_we[c] = commit && !word.is_tx && (chan == CSEL_W'(c));
    end

endmodule

// File: rtl/tsa_pulse_gen.sv
module tsa_pulse_gen
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_fall,
    input  pos_t              tx_pos,
    input  pos_t              rx_pos,
    input  logic [NUM_CH-1:0] tx_we,
    input  logic [NUM_CH-1:0] rx_we,
    input  assign_t           wr_asg,
    output logic [NUM_CH-1:0] fsx,
    output logic [NUM_CH-1:0] fsr,
    output logic              tslot_n
);

    assign_t           tx_tab [NUM_CH];
    assign_t           rx_tab [NUM_CH];
    logic [NUM_CH-1:0] tx_hit;
    logic [NUM_CH-1:0] rx_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                tx_tab[c] <= '0;
                rx_tab[c] <= '0;
            end else begin
                if (tx_we[c]) tx_tab[c] <= wr_asg;
                if (rx_we[c]) rx_tab[c] <= wr_asg;
            end
        end
        assign tx_hit[c] = slot_hit(tx_tab[c], tx_pos);
        assign rx_hit[c] = slot_hit(rx_tab[c], rx_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsx     <= '0;
            fsr     <= '0;
            tslot_n <= 1'b1;
        end else if (bclk_fall) begin
            fsx     <= tx_hit;
            fsr     <= rx_hit;
            tslot_n <= ~(|tx_hit);
        end
    end

endmodule

// File: rtl/tsa_codec_slots.sv
module tsa_codec_slots
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              tx_sync,
    input  logic              rsync_ch2,
    input  logic              mode,
    input  logic              ctl_clk,
    input  logic              ctl_sel_n,
    input  logic              ctl_data,
    input  logic [CSEL_W-2:0] ch_sel,
    output logic [NUM_CH-1:0] fsx,
    output logic [NUM_CH-1:0] fsr,
    output logic              tslot_n
);

    logic              bclk_d;
    logic              bclk_rise;
    logic              bclk_fall;
    logic              rx_start;
    logic [CSEL_W-1:0] csel;
    pos_t              tx_pos;
    pos_t              rx_pos;
    logic              tx_locked;
    logic              rx_locked;
    logic [NUM_CH-1:0] tx_we;
    logic [NUM_CH-1:0] rx_we;
    assign_t           wr_asg;

    always_ff @(posedge clk) begin
        if (rst) bclk_d <= 1'b0;
        else     bclk_d <= bclk;
    end

    assign bclk_rise = bclk && !bclk_d;
    assign bclk_fall = !bclk && bclk_d;

    // shared pin: receive frame-start in mode high, select msb in mode low
    assign rx_start  = mode ? rsync_ch2 : tx_sync;
    assign csel      = {(mode ? 1'b0 : rsync_ch2), ch_sel};

    assign tx_locked = tx_pos.locked;
    assign rx_locked = rx_pos.locked;

    tsa_slot_counter u_tx_cnt (
        .clk         (clk),
        .rst         (rst),
        .bclk_rise   (bclk_rise),
        .frame_start (tx_sync),
        .pos         (tx_pos)
    );

    tsa_slot_counter u_rx_cnt (
        .clk         (clk),
        .rst         (rst),
        .bclk_rise   (bclk_rise),
        .frame_start (rx_start),
        .pos         (rx_pos)
    );

    tsa_ctl_port u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_clk   (ctl_clk),
        .ctl_sel_n (ctl_sel_n),
        .ctl_data  (ctl_data),
        .csel      (csel),
        .tx_we     (tx_we),
        .rx_we     (rx_we),
        .wr_asg    (wr_asg)
    );

    tsa_pulse_gen u_pulse (
        .clk       (clk),
        .rst       (rst),
        .bclk_fall (bclk_fall),
        .tx_pos    (tx_pos),
        .rx_pos    (rx_pos),
        .tx_we     (tx_we),
        .rx_we     (rx_we),
        .wr_asg    (wr_asg),
        .fsx       (fsx),
        .fsr       (fsr),
        .tslot_n   (tslot_n)
    );

endmodule

// File: rtl/tsa_codec_slots_chk.sv
module tsa_codec_slots_chk
    import tsa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bclk,
    input logic [NUM_CH-1:0] fsx,
    input logic [NUM_CH-1:0] fsr,
    input logic              tslot_n,
    input logic              tx_locked,
    input logic              rx_locked,
    input logic [NUM_CH-1:0] tx_we,
    input logic [NUM_CH-1:0] rx_we
);

    localparam int unsigned NSTROBE = 2 * NUM_CH;

    logic                 bclk_q;
    logic                 fell;
    logic [NSTROBE-1:0]   all_fs;

    assign all_fs = {fsr, fsx};
    assign fell   = bclk_q && !bclk;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (fsx == '0 && fsr == '0 && tslot_n));

    // R3
    edge_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(all_fs) |-> ($past(bclk, 2) && !$past(bclk)));

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_we, tx_we}));

    // R10
    tx_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_locked |-> fsx == '0);

    // R10
    rx_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_locked |-> fsr == '0);

    for (genvar g = 0; g < NSTROBE; g++) begin : g_len
        logic [4:0] run;
        always_ff @(posedge clk) begin
            if (rst || !all_fs[g])      run <= '0;
            else if (fell && run != '1) run <= run + 5'd1;
        end
        // R3
        pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
            run <= 5'(BITS_PER_SLOT));
    end

endmodule

bind tsa_codec_slots tsa_codec_slots_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk),
    .fsx       (fsx),
    .fsr       (fsr),
    .tslot_n   (tslot_n),
    .tx_locked (tx_locked),
    .rx_locked (rx_locked),
    .tx_we     (tx_we),
    .rx_we     (rx_we)
);

// File: tb/tsa_codec_slots_tb_top.sv
module tsa_codec_slots_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0;
    logic       tx_sync = 1'b0;
    logic       mode = 1'b1;
    logic       ctl_clk = 1'b0;
    logic       ctl_sel_n = 1'b1;
    logic       ctl_data = 1'b0;
    logic [1:0] ch_sel = 2'd0;
    logic       rxs_b = 1'b0;
    logic       ch2_b = 1'b0;
    logic       rsync_ch2;
    logic [3:0] fsx;
    logic [3:0] fsr;
    logic       tslot_n;

    assign rsync_ch2 = mode ? rxs_b : ch2_b;

    tsa_codec_slots dut_i (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .tx_sync   (tx_sync),
        .rsync_ch2 (rsync_ch2),
        .mode      (mode),
        .ctl_clk   (ctl_clk),
        .ctl_sel_n (ctl_sel_n),
        .ctl_data  (ctl_data),
        .ch_sel    (ch_sel),
        .fsx       (fsx),
        .fsr       (fsr),
        .tslot_n   (tslot_n)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_min(string req, int act, int lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s: actual=%0d expected>=%0d", req, act, lo);
        end
    endtask

    // bit clock: 2 system clocks high, 2 low; frame-starts precede a rise
    int bdiv = 0;
    int rno = 0;
    int fbits = 512;
    int rx_off = 40;
    bit run_sync = 1'b0;

    always @(negedge clk) begin
        if (bdiv == 1) begin
            bdiv = 0;
            if (bclk) begin
                bclk = 1'b0;
                rno = rno + 1;
                tx_sync = run_sync && (rno % fbits == 0);
                rxs_b   = run_sync && (rno % fbits == rx_off);
            end else begin
                bclk = 1'b1;
            end
        end else begin
            bdiv = bdiv + 1;
        end
    end

    // behavioural reference, evaluated at every rising clock edge
    int tcnt, rcnt, nb, ch;
    bit tlk, rlk, bp, cp, sp, seen_rst = 1'b0;
    logic [3:0] ten, ren, mfsx, mfsr;
    int tsl[4];
    int rsl[4];
    logic [7:0] sh;
    bit mts;

    always @(posedge clk) begin
        bit brise, bfall, crise, srise, rs;
        if (rst) begin
            seen_rst = 1'b1;
            tcnt = 0; rcnt = 0; tlk = 0; rlk = 0;
            ten = '0; ren = '0; mfsx = '0; mfsr = '0; mts = 1'b1;
            sh = '0; nb = 0; ch = 0; bp = 0; cp = 0; sp = 1;
            for (int c = 0; c < 4; c++) begin tsl[c] = 0; rsl[c] = 0; end
        end else begin
            brise = bclk && !bp;
            bfall = !bclk && bp;
            crise = ctl_clk && !cp;
            srise = ctl_sel_n && !sp;
            rs = mode ? rsync_ch2 : tx_sync;
            if (bfall) begin
                for (int c = 0; c < 4; c++) begin
                    mfsx[c] = ten[c] && tlk && (tcnt / 8 == tsl[c]);
                    mfsr[c] = ren[c] && rlk && (rcnt / 8 == rsl[c]);
                end
                mts = !(|mfsx);
            end
            if (brise) begin
                if (tx_sync) begin tcnt = 0; tlk = 1; end
                else if (tlk) tcnt = (tcnt + 1) % 512;
                if (rs) begin rcnt = 0; rlk = 1; end
                else if (rlk) rcnt = (rcnt + 1) % 512;
            end
            if (srise && nb == 8 && ch < 4) begin
                if (sh[7]) begin ten[ch] = sh[6]; tsl[ch] = int'(sh[5:0]); end
                else       begin ren[ch] = sh[6]; rsl[ch] = int'(sh[5:0]); end
            end
            if (!ctl_sel_n && crise) begin
                sh = {sh[6:0], ctl_data};
                if (nb < 15) nb = nb + 1;
                ch = (mode ? 0 : (rsync_ch2 ? 4 : 0)) + int'(ch_sel);
            end
            if (ctl_sel_n) nb = 0;
            bp = bclk; cp = ctl_clk; sp = ctl_sel_n;
        end
    end

    // per-cycle comparison and pulse tracking
    int  run_len[8];
    bit  run_ok[8];
    int  np[8];
    int  ovl = 0;
    bit  wchk = 1'b0;

    always @(negedge clk) begin
        bit v;
        if (seen_rst && !rst && !done) begin
            check("R2/R3 fsx vs reference", int'(fsx), int'(mfsx));
            check("R4 fsr vs reference", int'(fsr), int'(mfsr));
            check("R5 tslot_n vs reference", int'(tslot_n), int'(mts));
            for (int k = 0; k < 8; k++) begin
                v = (k < 4) ? fsx[k] : fsr[k-4];
                if (v) begin
                    if (run_len[k] == 0) run_ok[k] = wchk;
                    run_len[k]++;
                end else if (run_len[k] > 0) begin
                    np[k]++;
                    if (run_ok[k] && wchk) check("R3 pulse width in clk", run_len[k], 32);
                    run_len[k] = 0;
                end
            end
            if (fsx[3] && fsr[3]) ovl++;
        end
    end

    task automatic clear_counts();
        for (int k = 0; k < 8; k++) np[k] = 0;
        ovl = 0;
    endtask

    function automatic logic [7:0] cw(bit tx, bit en, int slot);
        return {tx, en, 6'(slot)};
    endfunction

    // R6 serial write, MSB first; nbits other than 8 exercises R7
    task automatic send(int chan3, logic [7:0] w, int nbits);
        @(negedge clk);
        ch2_b = chan3[2];
        ch_sel = chan3[1:0];
        ctl_sel_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ctl_data = (i < 8) ? w[7-i] : 1'b0;
            repeat (3) @(negedge clk);
            ctl_clk = 1'b1;
            repeat (3) @(negedge clk);
            ctl_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ctl_sel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin run_len[k] = 0; run_ok[k] = 0; np[k] = 0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 fsx after reset", int'(fsx), 0);
        check("R1 fsr after reset", int'(fsr), 0);
        check("R1 tslot_n after reset", int'(tslot_n), 1);

        // R10: enabled assignment but no frame-start yet
        send(0, cw(1, 1, 0), 8);
        repeat (1000) @(negedge clk);
        check("R10 pulses before frame-start", np[0] + np[1] + np[2] + np[3], 0);

        // mode high: independent transmit and receive placements
        send(0, cw(1, 1, 2), 8);
        send(0, cw(0, 1, 2), 8);
        send(1, cw(1, 1, 63), 8);
        send(2, cw(0, 1, 0), 8);
        send(3, cw(1, 1, 3), 8);
        send(3, cw(0, 1, 3), 8);
        run_sync = 1'b1;
        repeat (2100) @(negedge clk);
        clear_counts();
        wchk = 1'b1;
        repeat (4200) @(negedge clk);
        check_min("R6 tx ch0 slot 2 pulses", np[0], 1);
        check_min("R2 tx ch1 slot 63 pulses", np[1], 1);
        check_min("R4 rx ch2 slot 0 pulses", np[6], 1);
        check("R4 rx ch1 unassigned", np[5], 0);
        check("R9 separate receive frame-start keeps ch3 apart", ovl, 0);

        // R7: wrong-length words are dropped
        wchk = 1'b0;
        send(2, cw(1, 1, 4), 7);
        send(2, cw(1, 1, 4), 9);
        repeat (2100) @(negedge clk);
        clear_counts();
        wchk = 1'b1;
        repeat (2200) @(negedge clk);
        check("R7 tx ch2 after 7 and 9 bit words", np[2], 0);

        // R8 steering and R11 disable
        wchk = 1'b0;
        send(1, cw(0, 1, 9), 8);
        send(0, cw(1, 0, 2), 8);
        repeat (2100) @(negedge clk);
        clear_counts();
        wchk = 1'b1;
        repeat (4200) @(negedge clk);
        check_min("R8 rx ch1 slot 9 pulses", np[5], 1);
        check_min("R8 rx ch0 untouched", np[4], 1);
        check("R11 tx ch0 disabled", np[0], 0);

        // R9: mode low, shared pin is select msb, receive follows tx_sync
        wchk = 1'b0;
        mode = 1'b0;
        send(5, cw(1, 0, 10), 8);
        send(2, cw(1, 1, 12), 8);
        repeat (2100) @(negedge clk);
        clear_counts();
        wchk = 1'b1;
        repeat (4200) @(negedge clk);
        check_min("R9 channel 5 ignored, tx ch1 still pulsing", np[1], 1);
        check_min("R9 channel 2 written in mode low", np[2], 1);
        check_min("R9 receive count follows tx_sync", ovl, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule